// File: doc/BRIEF.md
# Buffered Register Shadow Transfer Controller

This block keeps two timer-channel registers, a compare value and a compare-mode word. Each one has a shadow copy that software writes and an active copy that the comparator uses. Each register has its own 3-bit transfer mode. The mode chooses whether a write reaches the active copy at once, or waits for a counter event and is then copied across. The events come from an up/down counter outside this block: the counter is at zero, or the counter is at its peak. Some modes also require that the zero or peak interrupt-mask counter has reached zero.

After each transfer the block raises a one-cycle pulse. In buffered modes the read port of a register shows the shadow copy, so software can read back a write that is still waiting. In direct modes the read port shows the active copy.

Top module: `shadow_xfer_ctrl`

## Requirements
- R1: Reset clears both copies of both registers to zero, and both transfer pulses are low.
- R2: Mode 0 and mode 7 are direct: a write reaches the active copy on the next clock, the read port shows the active copy, and no transfer pulse is raised.
- R3: In buffered modes 1 to 6, a write changes only the shadow copy, and the read port shows the shadow copy from the next clock.
- R4: Mode 1 transfers at a clock where the counter-zero input is high; a peak event does nothing.
- R5: Mode 2 transfers at a clock where the counter-peak input is high; a zero event does nothing.
- R6: Mode 3 transfers on either a zero event or a peak event.
- R7: Mode 4 transfers only when counter-zero is high and the zero mask count equals 0.
- R8: Mode 5 transfers only when counter-peak is high and the peak mask count equals 0.
- R9: Mode 6 transfers when the mode 4 condition or the mode 5 condition holds.
- R10: A transfer happens only if a shadow write is pending. With no write since the last transfer, an event leaves the active copy unchanged and raises no pulse.
- R11: A transfer updates the active copy and raises the transfer pulse at the same clock edge. The pulse lasts exactly one cycle unless another transfer follows.
- R12: The two registers use their own modes, writes and pulses; activity on one never changes the other.
- R13: A write at the same clock as an event lets an earlier pending value transfer, and the new value stays pending. If no value was pending, nothing transfers and the new value waits.
- R14: Entering a direct mode (0 or 7) clears any pending write, so a value written earlier in a buffered mode is not transferred when buffering is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| val_wr | input | 1 | Write strobe for the compare value |
| val_wdata | input | VAL_W | Compare value write data |
| val_mode | input | 3 | Transfer mode of the compare value |
| cfg_wr | input | 1 | Write strobe for the compare-mode word |
| cfg_wdata | input | CFG_W | Compare-mode word write data |
| cfg_mode | input | 3 | Transfer mode of the compare-mode word |
| cnt_zero | input | 1 | Counter is at zero this cycle |
| cnt_peak | input | 1 | Counter is at peak this cycle |
| zmask_cnt | input | MASK_W | Current zero interrupt-mask count |
| pmask_cnt | input | MASK_W | Current peak interrupt-mask count |
| val_active | output | VAL_W | Active compare value |
| val_rdata | output | VAL_W | Compare value read port |
| val_xfer | output | 1 | One-cycle transfer pulse, compare value |
| cfg_active | output | CFG_W | Active compare-mode word |
| cfg_rdata | output | CFG_W | Compare-mode word read port |
| cfg_xfer | output | 1 | One-cycle transfer pulse, compare-mode word |

## Verification
Every mode is driven with the event that should fire it and with the event that should not. Zero events are sent to peak modes and peak events to zero modes. The gated modes get a nonzero mask count first, so a plain zero or peak match is shown to be blocked. Events without a pending write separate "event seen" from "data waiting". Writes in the same cycle as an event show which shadow value moves. A run of buffered writes followed by a switch to a direct mode shows that leaving buffering drops a pending value. Driving the two registers with different modes and different events shows that each one follows only its own mode.

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl #(
  parameter int VAL_W  = 16,
  parameter int CFG_W  = 16,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              val_wr,
  input  logic [VAL_W-1:0]  val_wdata,
  input  logic [2:0]        val_mode,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [2:0]        cfg_mode,
  input  logic              cnt_zero,
  input  logic              cnt_peak,
  input  logic [MASK_W-1:0] zmask_cnt,
  input  logic [MASK_W-1:0] pmask_cnt,
  output logic [VAL_W-1:0]  val_active,
  output logic [VAL_W-1:0]  val_rdata,
  output logic              val_xfer,
  output logic [CFG_W-1:0]  cfg_active,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              cfg_xfer
);

  logic [VAL_W-1:0] val_shadow;
  logic [CFG_W-1:0] cfg_shadow;
  logic             val_pend, cfg_pend;
  logic             zero_gated, peak_gated;
  logic             val_buf, cfg_buf, val_hit, cfg_hit;

  assign zero_gated = cnt_zero && (zmask_cnt == '0);
  assign peak_gated = cnt_peak && (pmask_cnt == '0);

  function automatic logic is_buffered(input logic [2:0] m);
    return (m != 3'd0) && (m != 3'd7);
  endfunction

  function automatic logic event_hit(input logic [2:0] m, input logic z, input logic p,
                                     input logic zg, input logic pg);
    case (m)
      3'd1:    return z;
      3'd2:    return p;
      3'd3:    return z | p;
      3'd4:    return zg;
      3'd5:    return pg;
      3'd6:    return zg | pg;
      default: return 1'b0;
    endcase
  endfunction

  assign val_buf = is_buffered(val_mode);
  assign cfg_buf = is_buffered(cfg_mode);
  assign val_hit = event_hit(val_mode, cnt_zero, cnt_peak, zero_gated, peak_gated) && val_pend;
  assign cfg_hit = event_hit(cfg_mode, cnt_zero, cnt_peak, zero_gated, peak_gated) && cfg_pend;

  assign val_rdata = val_buf ? val_shadow : val_active;
  assign cfg_rdata = cfg_buf ? cfg_shadow : cfg_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_shadow <= '0;
      val_active <= '0;
      val_pend   <= 1'b0;
      val_xfer   <= 1'b0;
    end else begin
      val_xfer <= 1'b0;
      if (!val_buf) begin
        val_pend <= 1'b0;
        if (val_wr) begin
          val_shadow <= val_wdata;
          val_active <= val_wdata;
        end
      end else begin
        if (val_hit) begin
          val_active <= val_shadow;
          val_xfer   <= 1'b1;
        end
        if (val_wr) begin
          val_shadow <= val_wdata;
          val_pend   <= 1'b1;
        end else if (val_hit) begin
          val_pend <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_shadow <= '0;
      cfg_active <= '0;
      cfg_pend   <= 1'b0;
      cfg_xfer   <= 1'b0;
    end else begin
      cfg_xfer <= 1'b0;
      if (!cfg_buf) begin
        cfg_pend <= 1'b0;
        if (cfg_wr) begin
          cfg_shadow <= cfg_wdata;
          cfg_active <= cfg_wdata;
        end
      end else begin
        if (cfg_hit) begin
          cfg_active <= cfg_shadow;
          cfg_xfer   <= 1'b1;
        end
        if (cfg_wr) begin
          cfg_shadow <= cfg_wdata;
          cfg_pend   <= 1'b1;
        end else if (cfg_hit) begin
          cfg_pend <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/shadow_xfer_chk.sv
module shadow_xfer_chk #(
  parameter int VAL_W  = 16,
  parameter int CFG_W  = 16,
  parameter int MASK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              val_wr,
  input logic [VAL_W-1:0]  val_wdata,
  input logic [2:0]        val_mode,
  input logic              cfg_wr,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [2:0]        cfg_mode,
  input logic [VAL_W-1:0]  val_active,
  input logic [VAL_W-1:0]  val_rdata,
  input logic              val_xfer,
  input logic [CFG_W-1:0]  cfg_active,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic              cfg_xfer
);

  // R2
  val_direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && (val_mode == 3'd0 || val_mode == 3'd7)) |=> (val_active == $past(val_wdata)));

  // R2
  cfg_direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_mode == 3'd0 || cfg_mode == 3'd7)) |=> (cfg_active == $past(cfg_wdata)));

  // R11
  val_xfer_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val_xfer) |-> (val_active == $past(val_rdata)));

  // R11
  cfg_xfer_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_xfer) |-> (cfg_active == $past(cfg_rdata)));

  // R2
  val_no_pulse_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_mode == 3'd0 || val_mode == 3'd7) |=> !val_xfer);

  // R2
  cfg_no_pulse_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd0 || cfg_mode == 3'd7) |=> !cfg_xfer);

  // R3
  val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_wr || (val_mode != 3'd0 && val_mode != 3'd7)) |=> (val_xfer || $stable(val_active)));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr || (cfg_mode != 3'd0 && cfg_mode != 3'd7)) |=> (cfg_xfer || $stable(cfg_active)));

endmodule

bind shadow_xfer_ctrl shadow_xfer_chk #(.VAL_W(VAL_W), .CFG_W(CFG_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .val_wr(val_wr), .val_wdata(val_wdata), .val_mode(val_mode),
  .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_mode(cfg_mode),
  .val_active(val_active), .val_rdata(val_rdata), .val_xfer(val_xfer),
  .cfg_active(cfg_active), .cfg_rdata(cfg_rdata), .cfg_xfer(cfg_xfer)
);

// File: tb/sim_shadow_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_shadow_xfer_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        val_wr = 1'b0, cfg_wr = 1'b0;
  logic [15:0] val_wdata = '0, cfg_wdata = '0;
  logic [2:0]  val_mode = '0, cfg_mode = '0;
  logic        cnt_zero = 1'b0, cnt_peak = 1'b0;
  logic [3:0]  zmask_cnt = '0, pmask_cnt = '0;
  logic [15:0] val_active, val_rdata, cfg_active, cfg_rdata;
  logic        val_xfer, cfg_xfer;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shadow_xfer_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .val_wr(val_wr), .val_wdata(val_wdata), .val_mode(val_mode),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_mode(cfg_mode),
    .cnt_zero(cnt_zero), .cnt_peak(cnt_peak),
    .zmask_cnt(zmask_cnt), .pmask_cnt(pmask_cnt),
    .val_active(val_active), .val_rdata(val_rdata), .val_xfer(val_xfer),
    .cfg_active(cfg_active), .cfg_rdata(cfg_rdata), .cfg_xfer(cfg_xfer)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic        wr;
    logic [15:0] d;
    logic        z;
    logic        p;
    logic [3:0]  zc;
    logic [3:0]  pc;
    logic [15:0] act;
    logic        x;
    logic [15:0] rd;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 16'h1111, 1'b0, 1'b0, 4'd0, 4'd0, 16'h1111, 1'b0, 16'h1111}, // R2
    '{3'd7, 1'b1, 16'h2222, 1'b0, 1'b0, 4'd0, 4'd0, 16'h2222, 1'b0, 16'h2222}, // R2
    '{3'd1, 1'b1, 16'h3333, 1'b0, 1'b0, 4'd0, 4'd0, 16'h2222, 1'b0, 16'h3333}, // R3
    '{3'd1, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, 4'd0, 16'h2222, 1'b0, 16'h3333}, // R4
    '{3'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd0, 16'h3333, 1'b1, 16'h3333}, // R4
    '{3'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd0, 16'h3333, 1'b0, 16'h3333}, // R10 R11
    '{3'd2, 1'b1, 16'h4444, 1'b1, 1'b0, 4'd0, 4'd0, 16'h3333, 1'b0, 16'h4444}, // R5
    '{3'd2, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, 4'd0, 16'h4444, 1'b1, 16'h4444}, // R5
    '{3'd3, 1'b1, 16'h5555, 1'b0, 1'b0, 4'd0, 4'd0, 16'h4444, 1'b0, 16'h5555}, // R6
    '{3'd3, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd0, 16'h5555, 1'b1, 16'h5555}, // R6
    '{3'd3, 1'b1, 16'h6666, 1'b0, 1'b0, 4'd0, 4'd0, 16'h5555, 1'b0, 16'h6666}, // R6
    '{3'd3, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, 4'd0, 16'h6666, 1'b1, 16'h6666}, // R6
    '{3'd4, 1'b1, 16'h7777, 1'b0, 1'b0, 4'd0, 4'd0, 16'h6666, 1'b0, 16'h7777}, // R7
    '{3'd4, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd2, 4'd0, 16'h6666, 1'b0, 16'h7777}, // R7
    '{3'd4, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, 4'd0, 16'h6666, 1'b0, 16'h7777}, // R7
    '{3'd4, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd3, 16'h7777, 1'b1, 16'h7777}, // R7
    '{3'd5, 1'b1, 16'h8888, 1'b0, 1'b0, 4'd0, 4'd0, 16'h7777, 1'b0, 16'h8888}, // R8
    '{3'd5, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, 4'd1, 16'h7777, 1'b0, 16'h8888}, // R8
    '{3'd5, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd0, 16'h7777, 1'b0, 16'h8888}, // R8
    '{3'd5, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd4, 4'd0, 16'h8888, 1'b1, 16'h8888}, // R8
    '{3'd6, 1'b1, 16'h9999, 1'b0, 1'b0, 4'd0, 4'd0, 16'h8888, 1'b0, 16'h9999}, // R9
    '{3'd6, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd1, 4'd0, 16'h8888, 1'b0, 16'h9999}, // R9
    '{3'd6, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, 4'd0, 16'h9999, 1'b1, 16'h9999}, // R9
    '{3'd6, 1'b1, 16'hAAAA, 1'b0, 1'b0, 4'd0, 4'd0, 16'h9999, 1'b0, 16'hAAAA}, // R9
    '{3'd6, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd5, 16'hAAAA, 1'b1, 16'hAAAA}, // R9
    '{3'd1, 1'b1, 16'hBBBB, 1'b1, 1'b0, 4'd0, 4'd0, 16'hAAAA, 1'b0, 16'hBBBB}, // R13
    '{3'd1, 1'b1, 16'hCCCC, 1'b1, 1'b0, 4'd0, 4'd0, 16'hBBBB, 1'b1, 16'hCCCC}, // R13
    '{3'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd0, 16'hCCCC, 1'b1, 16'hCCCC}, // R13
    '{3'd1, 1'b1, 16'hDDDD, 1'b0, 1'b0, 4'd0, 4'd0, 16'hCCCC, 1'b0, 16'hDDDD}, // R14
    '{3'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd0, 16'hCCCC, 1'b0, 16'hCCCC}, // R14 R2
    '{3'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd0, 16'hCCCC, 1'b0, 16'hDDDD}, // R14
    '{3'd1, 1'b0, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd0, 16'hCCCC, 1'b0, 16'hDDDD}  // R14
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 val_active", val_active, 16'h0);
    chk("R1 val_rdata", val_rdata, 16'h0);
    chk("R1 cfg_active", cfg_active, 16'h0);
    chk("R1 pulses", {14'd0, val_xfer, cfg_xfer}, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      val_mode  = VECS[i].m;
      val_wr    = VECS[i].wr;
      val_wdata = VECS[i].d;
      cnt_zero  = VECS[i].z;
      cnt_peak  = VECS[i].p;
      zmask_cnt = VECS[i].zc;
      pmask_cnt = VECS[i].pc;
      @(negedge clk);
      val_wr = 1'b0;
      chk($sformatf("vec%0d active", i), val_active, VECS[i].act);
      chk($sformatf("vec%0d pulse", i), {15'd0, val_xfer}, {15'd0, VECS[i].x});
      chk($sformatf("vec%0d rdata", i), val_rdata, VECS[i].rd);
    end
    cnt_zero = 1'b0;
    cnt_peak = 1'b0;

    // R12: cfg direct write leaves val alone
    val_mode = 3'd1;
    cfg_mode = 3'd0;
    cfg_wr = 1'b1;
    cfg_wdata = 16'h0F0F;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R12 cfg direct", cfg_active, 16'h0F0F);
    chk("R12 val untouched", val_active, 16'hCCCC);
    chk("R12 val no pulse", {15'd0, val_xfer}, 16'h0);

    // R12: different modes, different events
    cfg_mode = 3'd2;
    val_wr = 1'b1;
    val_wdata = 16'h1234;
    cfg_wr = 1'b1;
    cfg_wdata = 16'h5678;
    @(negedge clk);
    val_wr = 1'b0;
    cfg_wr = 1'b0;
    cnt_zero = 1'b1;
    @(negedge clk);
    cnt_zero = 1'b0;
    chk("R12 val xfer on zero", val_active, 16'h1234);
    chk("R12 val pulse", {15'd0, val_xfer}, 16'h1);
    chk("R12 cfg held on zero", cfg_active, 16'h0F0F);
    chk("R12 cfg no pulse", {15'd0, cfg_xfer}, 16'h0);
    chk("R12 cfg rdata shadow", cfg_rdata, 16'h5678);
    cnt_peak = 1'b1;
    @(negedge clk);
    cnt_peak = 1'b0;
    chk("R12 cfg xfer on peak", cfg_active, 16'h5678);
    chk("R12 cfg pulse", {15'd0, cfg_xfer}, 16'h1);
    chk("R12 val no pulse on peak", {15'd0, val_xfer}, 16'h0);
    chk("R12 val held", val_active, 16'h1234);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 val_active after reset", val_active, 16'h0);
    chk("R1 cfg_active after reset", cfg_active, 16'h0);
    chk("R1 cfg_rdata after reset", cfg_rdata, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule